// File: doc/BRIEF.md
# Active Shield Packet Exchange Controller

This block drives a digital anti-probe shield. The shield is a set of parallel top-metal lines that is split into equal packets of lines. On every exchange the controller takes one fresh keystream word from an external cipher and latches it into the transmit registers of a single packet. It waits a fixed number of cycles so the mesh can settle, then picks that same packet out of the received lines and compares it with the word it sent. A difference marks the packet as tampered. The packet index rotates over all packets, so every line carries unpredictable data in turn.

Software reaches the block through a simple register bus. Through that bus it loads the cipher key and the initialization vector byte by byte, turns the shield on or off, sets the exchange rate through a clock-enable divider, and reads or clears the per-packet alarm bits. A dedicated alarm wire gives an immediate interrupt whenever any packet bit is set. The cipher and the physical mesh sit outside this block.

Top module: `shield_ctrl`

## Requirements
- R1: After reset the status register and the alarm output are 0, all transmit lines are 0, ks_req is 0, the control and divider registers read 0 and key_out and iv_out are 0.
- R2: Each exchange launches the accepted keystream word onto exactly one packet, lines [p*PKT_W +: PKT_W], while all other transmit lines hold their values.
- R3: The packet index starts at 0 after reset, advances by one after every compare and wraps from NPKT-1 to 0, so launches visit packets 0,1,...,NPKT-1,0,...
- R4: A compare sets status bit p (address 0x02, bit p) only when the received lines of packet p differ from the word sent on them; a matching compare leaves the status unchanged.
- R5: Status bits are sticky: they stay set when the mesh later matches again. Writing address 0x02 clears each bit written as 1 and leaves each bit written as 0.
- R6: The alarm output is 1 exactly when at least one status bit is set.
- R7: When a status write and a mismatching compare land on the same clock edge, the bit set by the compare stays set while the other written bits are cleared.
- R8: Control bit 0 at address 0x00 enables the shield. While it is 0 no new exchange starts. An exchange already under way when it is cleared completes, so every word requested is launched.
- R9: The divider value at address 0x01 gives an exchange start opportunity every DIV+1 cycles, and writing it restarts the count. When DIV+1 is at least SETTLE_CYC+4, consecutive launches are exactly DIV+1 cycles apart.
- R10: A write of byte i to address 0x10+i sets key_out[8i+7:8i], and a write to 0x20+i sets iv_out[8i+7:8i]. IV bytes read back; key bytes always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW (6) | Register address |
| wr | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| key_out | output | KEY_W (128) | Cipher key to the keystream generator |
| iv_out | output | KEY_W (128) | Initialization vector to the keystream generator |
| ks_req | output | 1 | Keystream word request |
| ks_valid | input | 1 | Keystream word present; accepted while ks_req is 1 |
| ks_word | input | PKT_W (128) | Keystream word |
| tx_lines | output | LINES (640) | Transmit side of the mesh |
| rx_lines | input | LINES (640) | Receive side of the mesh |
| alarm | output | 1 | OR of all status bits |

## Verification
Two functions can meet on one edge: a software clear of the status register and a compare that finds a tampered packet. The bench forces this meeting. It injects a fault that always mismatches into one packet and watches the transmit lines to see when that packet is launched. From there it counts the settle cycles and drives a write of all ones to the status register on the compare cycle. It then expects only the tampered packet's bit to remain set and the alarm to stay high. The scoreboard predicts the result on its own: it holds every requested word and checks each launch for packet position, word content and rotation order. From the modelled mesh it then works out which packets should report tampering.

// File: rtl/shield_pkg.sv
package shield_pkg;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_REQ,
      SH_LAUNCH,
      SH_SETTLE,
      SH_CMP
   } sh_state_e;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_DIV  = 1;
   localparam int unsigned REG_STAT = 2;
   localparam int unsigned KEY_BASE = 16;
   localparam int unsigned IV_BASE  = 32;

endpackage

// File: rtl/shield_tick_gen.sv
module shield_tick_gen #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [DW-1:0] div,
   output logic          tick
);

   logic [DW-1:0] cnt_q;

   assign tick = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/shield_tx_bank.sv
module shield_tx_bank #(
   parameter  int LINES = 640,
   parameter  int PKT_W = 128,
   localparam int NPKT  = LINES / PKT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPKT-1:0]  en,
   input  logic [PKT_W-1:0] word,
   output logic [LINES-1:0] lines
);

   for (genvar g = 0; g < NPKT; g++) begin : g_pkt
      logic [PKT_W-1:0] bank_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q <= '0;
         else if (en[g])
            bank_q <= word;
      end

      assign lines[g*PKT_W +: PKT_W] = bank_q;
   end

endmodule

// File: rtl/shield_rx_check.sv
module shield_rx_check #(
   parameter  int LINES = 640,
   parameter  int PKT_W = 128,
   parameter  int IW    = 3,
   localparam int NPKT  = LINES / PKT_W
) (
   input  logic [LINES-1:0] rx_lines,
   input  logic [IW-1:0]    idx,
   input  logic [PKT_W-1:0] word,
   output logic             mismatch
);

   logic [PKT_W-1:0] pick;

   if (NPKT == 1) begin : g_single
      assign pick = rx_lines[PKT_W-1:0];
   end else begin : g_mux
      always_comb begin
         pick = '0;
         for (int p = 0; p < NPKT; p++)
            if (idx == IW'(p))
               pick = rx_lines[p*PKT_W +: PKT_W];
      end
   end

   assign mismatch = (pick != word);

endmodule

// File: rtl/shield_ctrl.sv
module shield_ctrl
   import shield_pkg::*;
#(
   parameter  int LINES      = 640,
   parameter  int PKT_W      = 128,
   parameter  int KEY_W      = 128,
   parameter  int SETTLE_CYC = 3,
   parameter  int DIV_W      = 8,
   parameter  int AW         = 6,
   localparam int NPKT       = LINES / PKT_W,
   localparam int IW         = (NPKT > 1) ? $clog2(NPKT) : 1,
   localparam int KEY_BYTES  = KEY_W / 8,
   localparam int SW         = $clog2(SETTLE_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             wr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic [KEY_W-1:0] key_out,
   output logic [KEY_W-1:0] iv_out,
   output logic             ks_req,
   input  logic             ks_valid,
   input  logic [PKT_W-1:0] ks_word,
   output logic [LINES-1:0] tx_lines,
   input  logic [LINES-1:0] rx_lines,
   output logic             alarm
);

   if (LINES % PKT_W != 0) begin : g_bad_lines
      $error("LINES must be a multiple of PKT_W");
   end
   if (NPKT > 8) begin : g_bad_npkt
      $error("status register holds at most 8 packets");
   end
   if ((KEY_W % 8 != 0) || (KEY_BYTES > 16)) begin : g_bad_key
      $error("KEY_W must be whole bytes, at most 16");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (DIV_W > 8) begin : g_bad_div
      $error("DIV_W must fit the 8-bit data bus");
   end
   if (AW < 6) begin : g_bad_aw
      $error("AW must cover the IV byte window");
   end

   logic             en_q;
   logic [DIV_W-1:0] div_q;
   logic [NPKT-1:0]  status_q;
   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] iv_q;
   sh_state_e        state_q, state_d;
   logic [IW-1:0]    idx_q;
   logic [PKT_W-1:0] word_q;
   logic [SW-1:0]    settle_q;
   logic             tick;
   logic             mismatch;
   logic [NPKT-1:0]  idx_hot;
   logic [NPKT-1:0]  tx_en;
   logic [NPKT-1:0]  set_vec;
   logic [NPKT-1:0]  clr_vec;
   logic             wr_ctrl, wr_div, wr_stat;

   assign wr_ctrl = wr && (addr == AW'(REG_CTRL));
   assign wr_div  = wr && (addr == AW'(REG_DIV));
   assign wr_stat = wr && (addr == AW'(REG_STAT));

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= '0;
         key_q <= '0;
         iv_q  <= '0;
      end else begin
         if (wr_ctrl) en_q  <= wdata[0];
         if (wr_div)  div_q <= wdata[DIV_W-1:0];
         for (int i = 0; i < KEY_BYTES; i++) begin
            if (wr && (addr == AW'(KEY_BASE + i))) key_q[8*i +: 8] <= wdata;
            if (wr && (addr == AW'(IV_BASE + i)))  iv_q[8*i +: 8]  <= wdata;
         end
      end
   end

   assign key_out = key_q;
   assign iv_out  = iv_q;

   always_comb begin
      rdata = '0;
      if (addr == AW'(REG_CTRL))
         rdata = {7'b0, en_q};
      else if (addr == AW'(REG_DIV))
         rdata = 8'(div_q);
      else if (addr == AW'(REG_STAT))
         rdata = 8'(status_q);
      for (int i = 0; i < KEY_BYTES; i++)
         if (addr == AW'(IV_BASE + i))
            rdata = iv_q[8*i +: 8];
   end

   shield_tick_gen #(.DW(DIV_W)) i_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_div),
      .div     (div_q),
      .tick    (tick)
   );

   // exchange sequencer
   always_comb begin
      state_d = state_q;
      case (state_q)
         SH_IDLE:   if (en_q && tick) state_d = SH_REQ;
         SH_REQ:    if (ks_valid)     state_d = SH_LAUNCH;
         SH_LAUNCH:                   state_d = SH_SETTLE;
         SH_SETTLE: if (settle_q == SW'(SETTLE_CYC - 1)) state_d = SH_CMP;
         SH_CMP:                      state_d = SH_IDLE;
         default:                     state_d = SH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SH_IDLE;
         idx_q    <= '0;
         word_q   <= '0;
         settle_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SH_REQ && ks_valid)
            word_q <= ks_word;
         if (state_q == SH_LAUNCH)
            settle_q <= '0;
         else if (state_q == SH_SETTLE)
            settle_q <= settle_q + 1'b1;
         if (state_q == SH_CMP) begin
            if (idx_q == IW'(NPKT - 1))
               idx_q <= '0;
            else
               idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign ks_req = (state_q == SH_REQ);

   always_comb begin
      idx_hot = '0;
      for (int p = 0; p < NPKT; p++)
         if (idx_q == IW'(p)) idx_hot[p] = 1'b1;
   end

   assign tx_en = (state_q == SH_LAUNCH) ? idx_hot : '0;

   shield_tx_bank #(.LINES(LINES), .PKT_W(PKT_W)) i_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tx_en),
      .word  (word_q),
      .lines (tx_lines)
   );

   shield_rx_check #(.LINES(LINES), .PKT_W(PKT_W), .IW(IW)) i_rx (
      .rx_lines (rx_lines),
      .idx      (idx_q),
      .word     (word_q),
      .mismatch (mismatch)
   );

   // sticky status, a new mismatch outranks a same-edge clear
   assign set_vec = (state_q == SH_CMP && mismatch) ? idx_hot : '0;
   assign clr_vec = wr_stat ? wdata[NPKT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= (status_q & ~clr_vec) | set_vec;
   end

   assign alarm = |status_q;

endmodule

// File: rtl/shield_ctrl_chk.sv
module shield_ctrl_chk
   import shield_pkg::*;
#(
   parameter int NPKT = 5,
   parameter int IW   = 3,
   parameter int AW   = 6
) (
   input logic            clk,
   input logic            rst_n,
   input sh_state_e       state,
   input logic [IW-1:0]   idx,
   input logic [NPKT-1:0] tx_en,
   input logic [NPKT-1:0] status,
   input logic            alarm,
   input logic            ks_req,
   input logic            enable,
   input logic            wr,
   input logic [AW-1:0]   addr
);

   // R2
   tx_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_en));

   // R2
   tx_en_then_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en != '0) |=> (state == SH_SETTLE));

   // R3
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SH_CMP) |=> $stable(idx));

   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, idx} < (IW+1)'(NPKT)));

   // R4
   status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) != '0) |-> ($past(state) == SH_CMP));

   // R5
   alarm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm) |-> $past(wr && (addr == AW'(REG_STAT))));

   // R8
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ks_req) |-> $past(enable));

endmodule

bind shield_ctrl shield_ctrl_chk #(.NPKT(NPKT), .IW(IW), .AW(AW)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .state  (state_q),
   .idx    (idx_q),
   .tx_en  (tx_en),
   .status (status_q),
   .alarm  (alarm),
   .ks_req (ks_req),
   .enable (en_q),
   .wr     (wr),
   .addr   (addr)
);

// File: tb/test_shield_ctrl.sv
`timescale 1ns/1ps
module test_shield_ctrl;

   localparam int LINES = 640;
   localparam int PKT   = 128;
   localparam int NP    = LINES / PKT;
   localparam int S     = 3;
   localparam int KW    = 128;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [5:0]       addr = '0;
   logic             wr = 1'b0;
   logic [7:0]       wdata = '0;
   logic [7:0]       rdata;
   logic [KW-1:0]    key_out, iv_out;
   logic             ks_req;
   logic             ks_valid = 1'b0;
   logic [PKT-1:0]   ks_word = '0;
   logic [LINES-1:0] tx_lines, rx_lines;
   logic             alarm;

   always #10 clk = ~clk;

   shield_ctrl #(.LINES(LINES), .PKT_W(PKT), .KEY_W(KW), .SETTLE_CYC(S)) i_shield_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
      .key_out(key_out), .iv_out(iv_out), .ks_req(ks_req), .ks_valid(ks_valid),
      .ks_word(ks_word), .tx_lines(tx_lines), .rx_lines(rx_lines), .alarm(alarm)
   );

   // mesh model: 0 intact, 1 stuck-1, 2 stuck-0, 3 swapped pair, 4 wired-AND short, 5 inverted
   int fmode = 0;
   int fa = 0;
   int fb = 0;
   always_comb begin
      rx_lines = tx_lines;
      case (fmode)
         1: rx_lines[fa] = 1'b1;
         2: rx_lines[fa] = 1'b0;
         3: begin rx_lines[fa] = tx_lines[fb]; rx_lines[fb] = tx_lines[fa]; end
         4: begin rx_lines[fa] = tx_lines[fa] & tx_lines[fb]; rx_lines[fb] = tx_lines[fa] & tx_lines[fb]; end
         5: rx_lines[fa] = ~tx_lines[fa];
         default: ;
      endcase
   end

   int nvec = 0;
   int nerr = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [PKT-1:0] gen_word(input int n);
      logic [PKT-1:0] w;
      for (int j = 0; j < 4; j++) begin
         logic [31:0] x;
         x = (32'(4*n + j) + 32'd1) * 32'h9E3779B1;
         w[32*j +: 32] = x ^ (x >> 15);
      end
      return w;
   endfunction

   // driver: keystream source, pushes each served word into the scoreboard
   logic [PKT-1:0] sb_q[$];
   int nreq = 0;
   always @(negedge clk) begin
      if (ks_req) begin
         ks_valid = 1'b1;
         ks_word  = gen_word(nreq);
         sb_q.push_back(ks_word);
         nreq++;
      end else begin
         ks_valid = 1'b0;
      end
   end

   // monitor: detects launches on the mesh and compares with the scoreboard
   logic [LINES-1:0] prev_tx = '0;
   logic [NP-1:0]    exp_stat = '0;
   int exp_idx = 0;
   int last_idx = -1;
   int launches = 0;
   int prev_t = 0;
   bit have_prev = 0;
   int spacing = 0;
   event ev_launch;
   always @(negedge clk) begin
      if (rst_n && tx_lines !== prev_tx) begin
         if (sb_q.size() == 0) begin
            check("R2 launch without request", 1, 0);
         end else begin
            logic [PKT-1:0] w;
            logic [LINES-1:0] others_now, others_old;
            w = sb_q.pop_front();
            check("R2/R3 word on packet slice", KW'(tx_lines[exp_idx*PKT +: PKT]), KW'(w));
            others_now = tx_lines;
            others_old = prev_tx;
            others_now[exp_idx*PKT +: PKT] = '0;
            others_old[exp_idx*PKT +: PKT] = '0;
            nvec++;
            if (others_now !== others_old) begin
               nerr++;
               $display("FAIL R2 other packets moved: actual %0h expected %0h", others_now, others_old);
            end
            if (rx_lines[exp_idx*PKT +: PKT] !== w) exp_stat[exp_idx] = 1'b1;
            if (spacing != 0 && have_prev)
               check("R9 launch spacing", KW'(cyc - prev_t), KW'(spacing));
            have_prev = 1;
            prev_t = cyc;
            last_idx = exp_idx;
            exp_idx = (exp_idx == NP - 1) ? 0 : exp_idx + 1;
            launches++;
            ->ev_launch;
         end
         prev_tx = tx_lines;
      end
   end

   task automatic bus_write(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = 6'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [7:0] d);
      @(negedge clk);
      addr = 6'(a);
      #1 d = rdata;
   endtask

   task automatic start_run(input int div);
      spacing = 0;
      have_prev = 0;
      bus_write(1, 8'(div));
      bus_write(0, 8'h01);
      spacing = div + 1;
   endtask

   task automatic stop_run();
      bus_write(0, 8'h00);
      spacing = 0;
      repeat (30) @(negedge clk);
   endtask

   task automatic wait_launches(input int n);
      int target;
      target = launches + n;
      while (launches < target) @(ev_launch);
   endtask

   task automatic check_status(input string tag);
      logic [7:0] d;
      bus_read(2, d);
      check(tag, KW'(d), KW'(exp_stat));
      check({tag, " alarm"}, KW'(alarm), KW'(|exp_stat));
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [KW-1:0] ek, ev;
      int n0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(2, d); check("R1 status", KW'(d), 0);
      check("R1 alarm", KW'(alarm), 0);
      check("R1 tx lines", KW'(|tx_lines), 0);
      check("R1 ks_req", KW'(ks_req), 0);
      bus_read(0, d); check("R1 ctrl", KW'(d), 0);
      bus_read(1, d); check("R1 div", KW'(d), 0);
      check("R1 key", key_out, 0);
      check("R1 iv", iv_out, 0);

      // R10 key and IV byte registers
      for (int i = 0; i < 16; i++) begin
         bus_write(16 + i, 8'(8'hA0 + i));
         bus_write(32 + i, 8'(8'h31 * i + 7));
         ek[8*i +: 8] = 8'(8'hA0 + i);
         ev[8*i +: 8] = 8'(8'h31 * i + 7);
      end
      check("R10 key_out", key_out, ek);
      check("R10 iv_out", iv_out, ev);
      bus_read(16 + 3, d); check("R10 key hidden", KW'(d), 0);
      bus_read(32 + 5, d); check("R10 iv readback", KW'(d), KW'(ev[8*5 +: 8]));

      // R2 R3 R9: intact mesh, 12 exchanges, 20-cycle spacing
      start_run(19);
      wait_launches(12);
      stop_run();
      check("R8 queue drained after disable", KW'(sb_q.size()), 0);
      check("R4 intact mesh no alarm", KW'(exp_stat), 0);
      check_status("R4 intact status");

      // R8 disabled: nothing launches
      n0 = launches;
      repeat (200) @(negedge clk);
      check("R8 no launch while disabled", KW'(launches), KW'(n0));

      // R4 stuck-at-1 in packet 2, R9 10-cycle spacing
      fmode = 1; fa = 2*PKT + 37;
      start_run(9);
      wait_launches(15);
      stop_run();
      check_status("R4 stuck-1 packet 2");
      check("R4 only packet 2 flagged", KW'(exp_stat & ~5'b00100), 0);

      // R5 write of zeros keeps, write of one clears
      bus_write(2, 8'h00);
      check_status("R5 zero write keeps");
      bus_write(2, 8'h04);
      exp_stat[2] = 1'b0;
      check_status("R5 one clears");

      // R4 swapped pair inside packet 4, then R5 sticky on an intact mesh
      fmode = 3; fa = 4*PKT + 3; fb = 4*PKT + 90;
      start_run(19);
      wait_launches(10);
      stop_run();
      check_status("R4 swap packet 4");
      fmode = 0;
      start_run(19);
      wait_launches(10);
      stop_run();
      check_status("R5 sticky after repair");

      // R4 short between packet 0 lines
      bus_write(2, 8'h1F); exp_stat = '0;
      fmode = 4; fa = 10; fb = 11;
      start_run(15);
      wait_launches(10);
      stop_run();
      check_status("R4 short packet 0");
      check("R6 alarm with flag", KW'(alarm), KW'(exp_stat != 0));
      bus_write(2, 8'h1F); exp_stat = '0;
      check("R6 alarm after clear", KW'(alarm), 0);

      // R7 clear-all write on the compare edge of a tampered packet 3
      fmode = 5; fa = 3*PKT + 5;
      start_run(19);
      do @(ev_launch); while (last_idx != 3);
      repeat (S) @(negedge clk);
      addr = 6'd2; wdata = 8'h1F; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      bus_read(2, d);
      check("R7 set wins over same-edge clear", KW'(d), KW'(8'h08));
      check("R7 alarm held", KW'(alarm), 1);
      stop_run();
      fmode = 0;

      finish_run();
   end

endmodule